// File: doc/BRIEF.md
# Processor System Register Block with Software Interrupt Requests

This block holds the small set of processor system registers that sit at the top of the physical address space: a software interrupt request word, a processor status word and an error register. It also answers reads of read-only words that give the memory size and a fixed system identity. A core reaches it through a word-wide register bus. The request side and the response side each use a valid/ready handshake.

Software sets request flags for levels 1 to 7 by writing the request word. The block finds the highest flag that is set. It mirrors that level number in two read-only fields of the same word. It then compares the level with the 3-bit priority field of the status word. When the pending level is strictly higher than the priority, the block issues a single-cycle trap request carrying a fixed vector. It issues no further trap request until the core acknowledges the current one.

Bus rules:
- The block accepts a request on a cycle where `req_valid` and `req_ready` are both high.
- It gives the response on the next cycle.
- A response that has not yet been taken holds `req_ready` low and keeps its data unchanged.

Top module: `sysreg_unit`

## Requirements
- R1: Writing the request word stores only data bits 15:9, which are the flags for levels 7..1 (bit 8+n requests level n). A read of the request word returns these bits as written. It returns the highest flagged level in both bits 3:1 and bits 7:5, and zero in bits 8, 4 and 0.
- R2: When no request flag is set, both level fields of the request word read as zero.
- R3: The error register, at address 0x3FFF6, stores only data bits 7:2. All other bits of it read as zero.
- R4: Reads of the fixed words return the following values, each with no error:
  - 0x3FFF0: the memory size in bytes divided by 64.
  - 0x3FFF2: 0.
  - 0x3FFF4: the identity 0x1170.
  - 0x3FFFC: 0.
- R5: Writes to 0x3FFF0, 0x3FFF2, 0x3FFF4, 0x3FFF8 and 0x3FFFC complete with no error and change no readable state. The status word, at 0x3FFFE, stores all 16 bits.
- R6: An error response is returned, with data zero and no change to any register, in each of these cases:
  - a read of 0x3FFF8;
  - an odd address;
  - any address not listed in R3, R4, R5, or the request word at 0x3FFFA.
- R7: When the highest flagged level is greater than status bits 7:5, `trap_valid` goes high for exactly one cycle with `trap_vector` = 9'o240 (0xA0). The pulse comes one cycle after the write that made the condition true.
- R8: No trap request is raised while the highest flagged level is less than or equal to the priority field, including when no flag is set.
- R9: After a trap request, no further request is raised until `trap_ack` is seen. If the condition still holds after the acknowledge, a new request follows.
- R10: After reset, the request word, error register and status word are zero, and `trap_valid` and `rsp_valid` are low.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` and `rsp_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 16 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Bus timeout error |
| trap_ack | input | 1 | Core has taken the trap request |
| trap_valid | output | 1 | Single-cycle trap request |
| trap_vector | output | 9 | Trap vector, 0o240 |

## Verification
The bench writes request words with only the lowest flag set, with only the highest flag set, with every flag set, and with only the ignored low byte set. A wrong priority encoder would mirror a lower level or a stale level. A design that stored the low byte would leak data bits into the level fields.

For traps, the bench checks these cases:
- the level equal to the priority, where a greater-or-equal comparison would trap wrongly;
- level 7 against priority 7 and against priority 6;
- a held condition before and after the acknowledge, where a missing pending flag would give repeated pulses.

The bench also reads the write-only hole and sends odd and out-of-window addresses. A decoder that treated these alike would either miss the timeout or raise it on the ignored writes.

Finally, the bench stalls the response path. A design that accepted a new request during the stall would overwrite the held read data.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W  = 16;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 7;
  localparam int VEC_W   = 9;
  localparam logic [VEC_W-1:0]  SWREQ_VECTOR = 9'o240;
  localparam logic [DATA_W-1:0] SYSTEM_IDENT = 16'h1170;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SIZE_LO,
    SEL_SIZE_HI,
    SEL_IDENT,
    SEL_ERRREG,
    SEL_HOLE,
    SEL_SWREQ,
    SEL_STKLIM,
    SEL_STATUS
  } reg_sel_e;
endpackage

// File: rtl/sysreg_prio_enc.sv
module sysreg_prio_enc #(
  parameter int N_REQ = 7,
  parameter int LVL_W = 3
) (
  input  logic [N_REQ-1:0] req,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req[i]) level = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(18'h3FFF0)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output reg_sel_e          sel,
  output logic              bad
);
  localparam logic [ADDR_W-1:0] A_SIZE_LO = WIN_BASE;
  localparam logic [ADDR_W-1:0] A_SIZE_HI = WIN_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IDENT   = WIN_BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ERRREG  = WIN_BASE + ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_HOLE    = WIN_BASE + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SWREQ   = WIN_BASE + ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_STKLIM  = WIN_BASE + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_STATUS  = WIN_BASE + ADDR_W'(14);

  always_comb begin
    case (addr)
      A_SIZE_LO: sel = SEL_SIZE_LO;
      A_SIZE_HI: sel = SEL_SIZE_HI;
      A_IDENT:   sel = SEL_IDENT;
      A_ERRREG:  sel = SEL_ERRREG;
      A_HOLE:    sel = SEL_HOLE;
      A_SWREQ:   sel = SEL_SWREQ;
      A_STKLIM:  sel = SEL_STKLIM;
      A_STATUS:  sel = SEL_STATUS;
      default:   sel = SEL_NONE;
    endcase
    // the hole only absorbs writes; reading it times out
    bad = (sel == SEL_NONE) || (!write && sel == SEL_HOLE);
  end
endmodule

// File: rtl/sysreg_trap.sv
module sysreg_trap #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 9,
  parameter logic [VEC_W-1:0] VECTOR = 9'o240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] prio,
  input  logic             ack,
  output logic             valid,
  output logic [VEC_W-1:0] vector,
  output logic             pending
);
  logic fire;
  assign fire   = (level > prio) && !pending;
  assign vector = VECTOR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      pending <= 1'b0;
    end else begin
      valid <= fire;
      if (fire)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sysreg_unit.sv
module sysreg_unit
  import sysreg_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int MEM_BYTES = 262144
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  input  logic                trap_ack,
  output logic                trap_valid,
  output logic [VEC_W-1:0]    trap_vector
);
  localparam int REQ_LSB = DATA_W - NUM_LVL;
  localparam logic [DATA_W-1:0] SIZE_WORD = DATA_W'(MEM_BYTES / 64);
  localparam int ERR_HI = 7;
  localparam int ERR_LO = 2;
  localparam int PRIO_LSB = 5;

  logic [NUM_LVL-1:0]      swreq_q;
  logic [ERR_HI-ERR_LO:0]  errreg_q;
  logic [DATA_W-1:0]       status_q;
  logic [LVL_W-1:0]        hi_level;
  logic [LVL_W-1:0]        cur_prio;
  logic                    trap_pend;
  logic [DATA_W-1:0]       swreq_word;
  logic [DATA_W-1:0]       rd_word;
  reg_sel_e                sel;
  logic                    bad;
  logic                    accept;
  logic                    do_write;

  sysreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .write (req_write),
    .sel   (sel),
    .bad   (bad)
  );

  sysreg_prio_enc #(.N_REQ(NUM_LVL), .LVL_W(LVL_W)) u_enc (
    .req   (swreq_q),
    .level (hi_level)
  );

  assign cur_prio = status_q[PRIO_LSB +: LVL_W];

  sysreg_trap #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VECTOR(SWREQ_VECTOR)) u_trap (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (hi_level),
    .prio    (cur_prio),
    .ack     (trap_ack),
    .valid   (trap_valid),
    .vector  (trap_vector),
    .pending (trap_pend)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_write  = accept && req_write && !bad;

  assign swreq_word = {swreq_q, 1'b0, hi_level, 1'b0, hi_level, 1'b0};

  always_comb begin
    case (sel)
      SEL_SIZE_LO: rd_word = SIZE_WORD;
      SEL_IDENT:   rd_word = SYSTEM_IDENT;
      SEL_ERRREG:  rd_word = DATA_W'({errreg_q, {ERR_LO{1'b0}}});
      SEL_SWREQ:   rd_word = swreq_word;
      SEL_STATUS:  rd_word = status_q;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= bad;
      rsp_rdata <= (bad || req_write) ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swreq_q  <= '0;
      errreg_q <= '0;
      status_q <= '0;
    end else if (do_write) begin
      case (sel)
        SEL_SWREQ:  swreq_q  <= req_wdata[DATA_W-1:REQ_LSB];
        SEL_ERRREG: errreg_q <= req_wdata[ERR_HI:ERR_LO];
        SEL_STATUS: status_q <= req_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk #(
  parameter int LVL_W = 3,
  parameter int N_REQ = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              trap_ack,
  input logic              trap_valid,
  input logic              trap_pend,
  input logic [LVL_W-1:0]  hi_level,
  input logic [LVL_W-1:0]  cur_prio,
  input logic [N_REQ-1:0]  swreq_q
);
  assert_none_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (swreq_q == '0) |-> (hi_level == '0));

  assert_err_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid);

  assert_above_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(hi_level > cur_prio));

  assert_wait_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend && !trap_ack) |=> !trap_valid);

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

bind sysreg_unit sysreg_chk #(.LVL_W(sysreg_pkg::LVL_W), .N_REQ(sysreg_pkg::NUM_LVL),
                              .DATA_W(sysreg_pkg::DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .trap_ack   (trap_ack),
  .trap_valid (trap_valid),
  .trap_pend  (trap_pend),
  .hi_level   (hi_level),
  .cur_prio   (cur_prio),
  .swreq_q    (swreq_q)
);

// File: tb/sim_sysreg_unit.sv
module sim_sysreg_unit;
  localparam int ADDR_W = 18;
  localparam int MEM_BYTES = 262144;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, trap_ack = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, trap_valid;
  logic [15:0] rsp_rdata;
  logic [8:0] trap_vector;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  logic [15:0] m_swreq, m_err, m_status;

  always #10 clk = ~clk;

  sysreg_unit #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .trap_ack(trap_ack), .trap_valid(trap_valid), .trap_vector(trap_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] level_word(input logic [15:0] flags);
    logic [2:0] l = 3'd0;
    for (int i = 9; i <= 15; i++) if (flags[i]) l = 3'(i - 8);
    return {flags[15:9], 1'b0, l, 1'b0, l, 1'b0};
  endfunction

  // {err, data} expected for an access, and model update for writes
  function automatic logic [16:0] expect_access(input logic wr, input logic [17:0] a,
                                                input logic [15:0] d);
    logic [16:0] r;
    case (a)
      18'h3FFF0: r = wr ? 17'h0 : {1'b0, 16'(MEM_BYTES / 64)};
      18'h3FFF2: r = 17'h0;
      18'h3FFF4: r = wr ? 17'h0 : {1'b0, 16'h1170};
      18'h3FFF6: begin r = wr ? 17'h0 : {1'b0, m_err}; if (wr) m_err = d & 16'h00FC; end
      18'h3FFF8: r = wr ? 17'h0 : 17'h10000;
      18'h3FFFA: begin r = wr ? 17'h0 : {1'b0, level_word(m_swreq)}; if (wr) m_swreq = d & 16'hFE00; end
      18'h3FFFC: r = 17'h0;
      18'h3FFFE: begin r = wr ? 17'h0 : {1'b0, m_status}; if (wr) m_status = d; end
      default:   r = 17'h10000;
    endcase
    return r;
  endfunction

  task automatic bus(input logic wr, input logic [17:0] a, input logic [15:0] d,
                     output logic [15:0] q, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    q = rsp_rdata; e = rsp_err;
    req_valid = 1'b0;
  endtask

  task automatic access(input string req, input logic wr, input logic [17:0] a,
                        input logic [15:0] d);
    logic [15:0] q; logic e; logic [16:0] x;
    x = expect_access(wr, a, d);
    bus(wr, a, d, q, e);
    check(req, {15'd0, e, q}, {15'd0, x});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_swreq = '0; m_err = '0; m_status = '0;
  endtask

  task automatic trap_expect(input string req, input logic v);
    @(negedge clk);
    check(req, {22'd0, trap_valid, trap_vector}, {22'd0, v, v ? 9'o240 : trap_vector});
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] q; logic e;
    do_reset();
    // R10 reset state
    check("R10 outputs", {29'd0, rsp_valid, trap_valid, req_ready}, 32'h1);
    access("R10 swreq", 0, 18'h3FFFA, 0);
    access("R10 err", 0, 18'h3FFF6, 0);
    access("R10 status", 0, 18'h3FFFE, 0);

    // R1 / R2 request word
    access("R1 wr", 1, 18'h3FFFA, 16'hFFFF); access("R1 all", 0, 18'h3FFFA, 0);
    check("R1 all value", {16'd0, level_word(m_swreq)}, 32'hFEEE);
    access("R1 wr", 1, 18'h3FFFA, 16'h0200); access("R1 lvl1", 0, 18'h3FFFA, 0);
    access("R1 wr", 1, 18'h3FFFA, 16'h8000); access("R1 lvl7", 0, 18'h3FFFA, 0);
    access("R1 wr", 1, 18'h3FFFA, 16'h0A00); access("R1 lvl3", 0, 18'h3FFFA, 0);
    access("R2 wr", 1, 18'h3FFFA, 16'h01FF); access("R2 none", 0, 18'h3FFFA, 0);
    // R3 error register
    access("R3 wr", 1, 18'h3FFF6, 16'hFFFF); access("R3 rd", 0, 18'h3FFF6, 0);
    // R4 constants
    access("R4 size", 0, 18'h3FFF0, 0); access("R4 upper", 0, 18'h3FFF2, 0);
    access("R4 ident", 0, 18'h3FFF4, 0); access("R4 stklim", 0, 18'h3FFFC, 0);
    // R5 ignored writes
    access("R5 size", 1, 18'h3FFF0, 16'h1234); access("R5 ident", 1, 18'h3FFF4, 16'hFFFF);
    access("R5 hole", 1, 18'h3FFF8, 16'hFFFF); access("R5 stk", 1, 18'h3FFFC, 16'hFFFF);
    access("R5 upper", 1, 18'h3FFF2, 16'hFFFF);
    access("R5 size after", 0, 18'h3FFF0, 0); access("R5 ident after", 0, 18'h3FFF4, 0);
    access("R5 stk after", 0, 18'h3FFFC, 0);
    access("R5 status wr", 1, 18'h3FFFE, 16'hA5E1); access("R5 status rd", 0, 18'h3FFFE, 0);
    // R6 errors, no state change
    access("R6 hole rd", 0, 18'h3FFF8, 0);
    access("R6 odd wr", 1, 18'h3FFFB, 16'hFFFF);
    access("R6 out wr", 1, 18'h3FFEE, 16'hFFFF);
    access("R6 out rd", 0, 18'h00010, 0);
    access("R6 swreq kept", 0, 18'h3FFFA, 0);

    // R7..R9 traps
    do_reset();
    trap_ack = 1'b0;
    access("R7 prio3", 1, 18'h3FFFE, 16'h0060);
    access("R7 lvl4", 1, 18'h3FFFA, 16'h1000);
    trap_expect("R7 pulse", 1);
    trap_expect("R7 single", 0);
    repeat (3) trap_expect("R9 held", 0);
    @(negedge clk); trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0;
    trap_expect("R9 refire", 1);
    access("R8 lvl3 eq", 1, 18'h3FFFA, 16'h0800);
    @(negedge clk); trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0;
    repeat (4) trap_expect("R8 equal", 0);
    access("R8 prio7", 1, 18'h3FFFE, 16'h00E0);
    access("R8 all", 1, 18'h3FFFA, 16'hFE00);
    repeat (3) trap_expect("R8 lvl7 prio7", 0);
    access("R7 prio6", 1, 18'h3FFFE, 16'h00C0);
    trap_expect("R7 lvl7 prio6", 1);
    trap_expect("R7 lvl7 single", 0);

    // R11 back-pressure
    @(negedge clk); trap_ack = 1'b1; rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h3FFF4;
    @(negedge clk);
    check("R11 first", {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, 16'h1170});
    req_addr = 18'h3FFF0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 stall", {14'd0, req_ready, rsp_err, rsp_rdata}, {14'd0, 1'b0, 1'b0, 16'h1170});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 second", {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, 16'(MEM_BYTES / 64)});
    @(negedge clk);
    check("R11 drained", {31'd0, rsp_valid}, 32'd0);

    // random mix against the model (trap_ack held high)
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int n = 0; n < 400; n++) begin
      logic [17:0] a;
      logic [3:0] pick = 4'($urandom_range(0, 9));
      case (pick)
        4'd8: a = 18'h3FFF1;
        4'd9: a = 18'h3FFE0 + 18'($urandom_range(0, 7) * 2);
        default: a = 18'h3FFF0 + 18'(pick * 2);
      endcase
      access("R6 random", 1'($urandom_range(0, 1)), a, 16'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule